// File: doc/BRIEF.md
# Power-On and Brownout Reset Sequencer

This block gathers every reason the core may need to be held in reset and decides when the core may run again. A digital supply-good flag stands in for the analog supply comparator. While that flag is low, the whole block is forced into its power-off state. When the flag rises, the block enables the high-frequency clock source and counts a long, fixed number of that clock's cycles. Only then does it let the core go. A supply dip that recovers is treated the same as a cold start, and the count always begins again from zero.

Once the core is running, three other sources can pull it back into reset. A watchdog pulse and a software request each hold the core in reset for a short fixed time. The active-low external pin is first passed through a two-flop synchronizer, and it then holds the core in reset for as long as the pin stays low. The core sees the same reset state whatever the source. A cause register shows which source or sources started the most recent reset. On every release, the block pulses a load strobe and presents the start address for the program counter.

Top module: `reset_release_seq`

## Requirements
- R1: While supply_ok_i is low, core_rst_o is 1, fll_en_o is 0, pc_load_o is 0 and cause_o is 4'b0001. These values apply immediately and need no clock edge.
- R2: fll_en_o becomes 1 at the first rising clock edge after supply_ok_i rises. It stays 1 until supply_ok_i falls.
- R3: core_rst_o goes to 0 at the POR_CYCLES-th rising edge after supply_ok_i rises (default 65536). At every earlier edge it is still 1.
- R4: When supply_ok_i falls at any time, including part way through the delay count, the block enters the R1 state at once. The next power-up counts the full POR_CYCLES from zero.
- R5: ext_rst_n_i is active low. A fall of the pin asserts core_rst_o at the third rising edge after the fall, and a rise releases it at the third rising edge after the rise. Reset stays asserted for as long as the pin is low.
- R6: A one-cycle watchdog pulse (wdt_rst_i) or software pulse (sw_rst_i), sampled while the core runs, raises core_rst_o at that edge. core_rst_o then stays high for exactly HOLD_CYCLES cycles (default 16).
- R7: Watchdog and software pulses that arrive while reset is already asserted are ignored. They do not lengthen the reset and do not change cause_o.
- R8: cause_o bit 0 flags power-on, bit 1 watchdog, bit 2 external pin and bit 3 software. When reset is entered from the running state, cause_o takes the set of all sources active at that edge and clears every other bit. It then holds that value until the next such entry or the next power loss.
- R9: pc_load_o is 1 for exactly one cycle, the cycle in which core_rst_o first reads 0. start_pc_o always carries RESET_PC (default 16'h8000).
- R10: If the synchronized external pin is still low when the power-on count or the internal hold ends, reset stays asserted until the pin is released, with the R5 latency. In this case cause_o keeps the value it had.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | High-frequency clock, free running whenever supply is good |
| supply_ok_i | input | 1 | Supply-good flag, low means power is out of tolerance |
| wdt_rst_i | input | 1 | Watchdog reset pulse, one cycle |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| sw_rst_i | input | 1 | Software reset request pulse, one cycle |
| core_rst_o | output | 1 | Reset to the core, active high |
| fll_en_o | output | 1 | Enable for the high-frequency clock source |
| cause_o | output | 4 | Reset cause flags {software, external, watchdog, power-on} |
| pc_load_o | output | 1 | One-cycle strobe to load the program counter on release |
| start_pc_o | output | PC_W | Program counter start address |

## Verification
A synchronized external pin fall and a watchdog pulse can reach the running-state decision at the same edge. The bench provokes this by dropping the pin two edges ahead of a watchdog pulse, so that both are seen together. It then expects a cause of 4'b0110 and a reset that outlasts the internal hold for as long as the pin stays low. Random runs with a fixed seed mix watchdog, software, combined and external-pin resets at random gaps. Every release edge is predicted from the requirement latencies and cross-checked against the expected cause.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  localparam int CAUSE_W = 4;
  localparam int CB_POR  = 0;
  localparam int CB_WDT  = 1;
  localparam int CB_EXT  = 2;
  localparam int CB_SW   = 3;

  typedef enum logic [1:0] {
    ST_PWR_WAIT = 2'd0,
    ST_RUN      = 2'd1,
    ST_INT_HOLD = 2'd2,
    ST_EXT_HOLD = 2'd3
  } seq_state_e;

  // Assemble a cause vector from individual source flags.
  function automatic logic [CAUSE_W-1:0] cause_vec(input logic por, input logic wdt,
                                                   input logic ext, input logic sw);
    logic [CAUSE_W-1:0] v;
    v         = '0;
    v[CB_POR] = por;
    v[CB_WDT] = wdt;
    v[CB_EXT] = ext;
    v[CB_SW]  = sw;
    return v;
  endfunction

  // Counter width able to hold the largest terminal value.
  function automatic int count_width(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return (m > 1) ? $clog2(m) : 1;
  endfunction

endpackage

// File: rtl/rsq_pin_sync.sv
module rsq_pin_sync #(
  parameter int  STAGES   = 2,
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic pin_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{IDLE_VAL}};
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
    end
  end

  assign pin_o = chain_q[STAGES-1];

endmodule

// File: rtl/rsq_delay_counter.sv
module rsq_delay_counter #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          en_i,
  input  logic [CW-1:0] term_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = en_i && (cnt_q == term_i);

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q <= term_i)); // R3

endmodule

// File: rtl/rsq_cause_reg.sv
module rsq_cause_reg
  import rsq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               capture_i,
  input  logic [CAUSE_W-1:0] src_i,
  output logic [CAUSE_W-1:0] cause_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_o <= cause_vec(1'b1, 1'b0, 1'b0, 1'b0);
    end else if (capture_i) begin
      cause_o <= src_i;
    end
  end

  AST_CAUSE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(cause_o)); // R8

  AST_CAUSE_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_o != '0); // R8

endmodule

// File: rtl/reset_release_seq.sv
module reset_release_seq
  import rsq_pkg::*;
#(
  parameter int              POR_CYCLES  = 65536,
  parameter int              HOLD_CYCLES = 16,
  parameter int              PC_W        = 16,
  parameter logic [PC_W-1:0] RESET_PC    = 'h8000
) (
  input  logic               clk_i,
  input  logic               supply_ok_i,
  input  logic               wdt_rst_i,
  input  logic               ext_rst_n_i,
  input  logic               sw_rst_i,
  output logic               core_rst_o,
  output logic               fll_en_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               pc_load_o,
  output logic [PC_W-1:0]    start_pc_o
);

  localparam int            CW       = count_width(POR_CYCLES, HOLD_CYCLES);
  localparam logic [CW-1:0] POR_TERM = CW'(POR_CYCLES - 1);
  localparam logic [CW-1:0] HLD_TERM = CW'(HOLD_CYCLES - 1);

  seq_state_e state_q, state_d;
  logic       fll_q, load_q;

  // Named internal events
  logic       ext_pin_sync;
  logic       ext_req;
  logic       int_req;
  logic       run_trip;
  logic       cnt_done;
  logic       cnt_en;
  logic       cnt_clear;
  logic       release_evt;
  logic [CW-1:0] cnt_term;

  rsq_pin_sync #(.STAGES(2), .IDLE_VAL(1'b1)) u_pin_sync (
    .clk_i  (clk_i),
    .rst_ni (supply_ok_i),
    .pin_i  (ext_rst_n_i),
    .pin_o  (ext_pin_sync)
  );

  assign ext_req  = !ext_pin_sync;
  assign int_req  = wdt_rst_i | sw_rst_i;
  assign run_trip = (state_q == ST_RUN) && (int_req || ext_req);

  assign cnt_en    = (state_q == ST_PWR_WAIT) || (state_q == ST_INT_HOLD);
  assign cnt_clear = (state_q == ST_RUN) || (state_q == ST_EXT_HOLD);
  assign cnt_term  = (state_q == ST_PWR_WAIT) ? POR_TERM : HLD_TERM;

  rsq_delay_counter #(.CW(CW)) u_delay (
    .clk_i   (clk_i),
    .rst_ni  (supply_ok_i),
    .clear_i (cnt_clear),
    .en_i    (cnt_en),
    .term_i  (cnt_term),
    .done_o  (cnt_done)
  );

  rsq_cause_reg u_cause (
    .clk_i     (clk_i),
    .rst_ni    (supply_ok_i),
    .capture_i (run_trip),
    .src_i     (cause_vec(1'b0, wdt_rst_i, ext_req, sw_rst_i)),
    .cause_o   (cause_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PWR_WAIT: if (cnt_done) state_d = ext_req ? ST_EXT_HOLD : ST_RUN;
      ST_RUN: begin
        if (int_req)      state_d = ST_INT_HOLD;
        else if (ext_req) state_d = ST_EXT_HOLD;
      end
      ST_INT_HOLD: if (cnt_done) state_d = ext_req ? ST_EXT_HOLD : ST_RUN;
      ST_EXT_HOLD: if (!ext_req) state_d = ST_RUN;
      default:     state_d = ST_PWR_WAIT;
    endcase
  end

  assign release_evt = (state_q != ST_RUN) && (state_d == ST_RUN);

  always_ff @(posedge clk_i or negedge supply_ok_i) begin
    if (!supply_ok_i) begin
      state_q <= ST_PWR_WAIT;
      fll_q   <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      fll_q   <= 1'b1;
      load_q  <= release_evt;
    end
  end

  assign core_rst_o = (state_q != ST_RUN);
  assign fll_en_o   = fll_q;
  assign pc_load_o  = load_q;
  assign start_pc_o = RESET_PC;

  AST_RUN_NEEDS_FLL: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
    !core_rst_o |-> fll_en_o); // R2

  AST_PC_LOAD_AT_RELEASE: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
    $fell(core_rst_o) |-> pc_load_o); // R9

  AST_PC_LOAD_SINGLE: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
    pc_load_o |=> !pc_load_o); // R9

  AST_TRIP_ASSERTS_RST: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
    run_trip |=> core_rst_o); // R6

  AST_EXT_KEEPS_RST: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
    (ext_req && core_rst_o) |=> core_rst_o); // R10

  AST_POR_CAUSE_IN_WAIT: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
    (state_q == ST_PWR_WAIT) |-> (cause_o == cause_vec(1'b1, 1'b0, 1'b0, 1'b0))); // R8

endmodule

// File: tb/test_reset_release_seq.sv
module test_reset_release_seq;

  localparam int CLK_PERIOD = 10;
  localparam int P_CYC      = 40;
  localparam int H_CYC      = 6;
  localparam int WD_LIMIT   = 20000;

  logic        clk = 1'b0;
  logic        supply_ok = 1'b0;
  logic        wdt = 1'b0;
  logic        ext_n = 1'b1;
  logic        sw = 1'b0;
  logic        core_rst, fll_en, pc_load;
  logic [3:0]  cause;
  logic [15:0] start_pc;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_release_seq #(.POR_CYCLES(P_CYC), .HOLD_CYCLES(H_CYC)) i_reset_release_seq (
    .clk_i       (clk),
    .supply_ok_i (supply_ok),
    .wdt_rst_i   (wdt),
    .ext_rst_n_i (ext_n),
    .sw_rst_i    (sw),
    .core_rst_o  (core_rst),
    .fll_en_o    (fll_en),
    .cause_o     (cause),
    .pc_load_o   (pc_load),
    .start_pc_o  (start_pc)
  );

  // Expected cause: bit0 power-on, bit1 watchdog, bit2 external, bit3 software.
  function automatic logic [3:0] exp_cause(input bit por, input bit w, input bit e, input bit s);
    return {s, e, w, por};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Raise supply and walk the full delay; ext held low keeps the core in reset afterwards.
  task automatic power_up(input string tag, input bit ext_low);
    @(negedge clk) supply_ok = 1'b1;
    #1 chk({tag, " R2 fll off before first edge"}, fll_en, 0);
    @(posedge clk);
    @(negedge clk) chk({tag, " R2 fll on after first edge"}, fll_en, 1);
    repeat (P_CYC - 2) @(posedge clk);
    @(negedge clk) chk({tag, " R3 still in reset at edge P-1"}, core_rst, 1);
    @(posedge clk);
    @(negedge clk);
    if (!ext_low) begin
      chk({tag, " R3 released at edge P"}, core_rst, 0);
      chk({tag, " R9 pc load pulse"}, pc_load, 1);
      chk({tag, " R9 start pc"}, start_pc, 16'h8000);
      chk({tag, " R8 cause power-on"}, cause, exp_cause(1, 0, 0, 0));
      @(negedge clk) chk({tag, " R9 pc load one cycle"}, pc_load, 0);
    end else begin
      chk({tag, " R10 held by pin at end of count"}, core_rst, 1);
      chk({tag, " R10 cause kept"}, cause, exp_cause(1, 0, 0, 0));
    end
  endtask

  // Internal pulse; with extra set, a second pulse lands inside the hold.
  task automatic int_pulse(input bit w, input bit s, input bit extra);
    logic [3:0] ec;
    ec = exp_cause(0, w, 0, s);
    @(negedge clk) begin wdt = w; sw = s; end
    @(posedge clk);
    @(negedge clk) begin wdt = 1'b0; sw = 1'b0; end
    chk("R6 reset raised by pulse", core_rst, 1);
    chk("R8 cause after pulse", cause, ec);
    if (extra) begin
      wdt = 1'b1; sw = 1'b1;
      @(posedge clk);
      @(negedge clk) begin wdt = 1'b0; sw = 1'b0; end
      chk("R7 cause unchanged by pulse in reset", cause, ec);
      repeat (H_CYC - 2) @(posedge clk);
    end else begin
      repeat (H_CYC - 1) @(posedge clk);
    end
    @(negedge clk) chk("R6 reset held through last hold cycle", core_rst, 1);
    @(posedge clk);
    @(negedge clk) chk("R6 R7 released after hold", core_rst, 0);
    chk("R9 pc load after hold", pc_load, 1);
    chk("R8 cause kept after release", cause, ec);
  endtask

  task automatic release_pin(input string tag);
    ext_n = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk) chk({tag, " R5 held two edges after rise"}, core_rst, 1);
    @(posedge clk);
    @(negedge clk) chk({tag, " R5 released third edge after rise"}, core_rst, 0);
    chk({tag, " R9 pc load after pin"}, pc_load, 1);
  endtask

  task automatic ext_pulse(input int len);
    @(negedge clk) ext_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk) chk("R5 not yet asserted two edges after fall", core_rst, 0);
    @(posedge clk);
    @(negedge clk) chk("R5 asserted third edge after fall", core_rst, 1);
    chk("R8 cause external", cause, exp_cause(0, 0, 1, 0));
    repeat (len) @(posedge clk);
    @(negedge clk) chk("R5 held while pin low", core_rst, 1);
    release_pin("ext");
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R1 core reset while supply low", core_rst, 1);
    chk("R1 fll off while supply low", fll_en, 0);
    chk("R1 no pc load while supply low", pc_load, 0);
    chk("R1 cause while supply low", cause, exp_cause(1, 0, 0, 0));

    power_up("cold", 1'b0);

    // R4: brownout part way through the count, then a full recount
    @(negedge clk) supply_ok = 1'b0;
    #1 chk("R4 immediate reset on supply loss", core_rst, 1);
    chk("R4 fll off on supply loss", fll_en, 0);
    @(negedge clk) supply_ok = 1'b1;
    repeat (20) @(posedge clk);
    @(negedge clk) supply_ok = 1'b0;
    #1 chk("R4 reset during count", core_rst, 1);
    chk("R4 R1 cause after brownout", cause, exp_cause(1, 0, 0, 0));
    repeat (2) @(negedge clk);
    power_up("R4 recount", 1'b0);

    int_pulse(1'b1, 1'b0, 1'b0);
    int_pulse(1'b0, 1'b1, 1'b0);
    int_pulse(1'b1, 1'b0, 1'b1);
    ext_pulse(4);

    // Same-edge collision: synchronized pin and watchdog meet in one cycle
    @(negedge clk) ext_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk) wdt = 1'b1;
    @(posedge clk);
    @(negedge clk) wdt = 1'b0;
    chk("R8 combined cause watchdog and pin", cause, exp_cause(0, 1, 1, 0));
    repeat (H_CYC) @(posedge clk);
    @(negedge clk) chk("R10 hold outlasted by low pin", core_rst, 1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    release_pin("R10 collision");

    // R10 at the end of the power-on count
    @(negedge clk) supply_ok = 1'b0;
    ext_n = 1'b0;
    repeat (2) @(negedge clk);
    power_up("R10 por", 1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    release_pin("R10 por");

    // Constrained random mix
    for (int i = 0; i < 30; i++) begin
      int gap;
      int kind;
      gap  = 1 + ($urandom % 8);
      kind = $urandom % 4;
      repeat (gap) @(negedge clk);
      chk("R6 running before random stimulus", core_rst, 0);
      case (kind)
        0: int_pulse(1'b1, 1'b0, ($urandom % 2) == 1);
        1: int_pulse(1'b0, 1'b1, 1'b0);
        2: int_pulse(1'b1, 1'b1, 1'b0);
        default: ext_pulse($urandom % 5);
      endcase
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R3 watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule